// File: doc/BRIEF.md
# Dual-Rail Power-On Reset Sequencer

This block holds a chip-level power-on reset low until two supplies have qualified. The first is a high-voltage input rail and the second is a core-logic rail. Each rail has its own qualification timer. The timers count cycles of a slow real-time clock of about 32 kHz, so the delays are only as accurate as that clock. A timer starts counting only once the real-time oscillator reports that it is ready. The internal reset is released when both timers have finished. The rails may become valid in either order.

The internal release is then combined with an optional active-low external reset request and with a set of rail-stable flags to form the final system reset. A condition that starts to hold reset pulls the reset outputs low at once, without waiting for a clock edge. Every release happens on a clock edge, after the condition has passed through a two-flop synchroniser. A small status vector shows which conditions are still holding the system in reset. The `rst_i` input is a synchronous, active-high initialisation that clears all state.

Top module: `por_seq`

## Requirements
- R1: While `rst_i` is high at a clock edge, that edge clears all timers and synchronisers. Afterwards `por_int_n_o` and `sys_rst_n_o` are 0 and `hold_o` is 4'b1111 until the inputs qualify again.
- R2: The high-voltage rail qualifies on the HV_CYCLES-th (default 131) clock edge at which its synchronised valid is high and the oscillator is ready. `hv_valid_i` rising before clock edge 1 is first seen by the timer at edge 3 (two synchroniser stages), so it qualifies at edge HV_CYCLES+2.
- R3: The core rail qualifies in the same way after CORE_CYCLES (default 33) counted edges, which is edge CORE_CYCLES+2 after `core_valid_i` rises.
- R4: `por_int_n_o` is 1 only while both rails are qualified and both valid inputs are high. The order in which the rails become valid has no effect on this.
- R5: While the synchronised oscillator-ready flag is low, neither timer advances. After `osc_ready_i` rises, a rail that is already valid qualifies on edge HV_CYCLES+2 (or CORE_CYCLES+2) counted from that rise.
- R6: If a valid input drops for long enough to reach the synchroniser output, that rail's timer clears. When the input returns, a full delay is counted again from zero.
- R7: When `hv_valid_i` or `core_valid_i` falls, `por_int_n_o` and `sys_rst_n_o` go to 0 in the same instant, with no clock edge in between.
- R8: `sys_rst_n_o` is 0 at once while `ext_rst_n_i` is 0. After `ext_rst_n_i` rises before edge 1, the external term no longer holds reset from edge 2 onward.
- R9: `sys_rst_n_o` is 0 at once while any bit of `rail_stable_i` is 0. After the last low bit rises before edge 1, the stable term no longer holds reset from edge 2 onward.
- R10: `hold_o` bit 0 is 1 while the high-voltage rail is not qualified or its valid is low, and bit 1 is the same for the core rail. Bit 2 is 1 while the external term holds reset (R8), and bit 3 is 1 while the stable term holds reset (R9). `sys_rst_n_o` is 1 exactly when `hold_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Real-time clock, about 32 kHz |
| rst_i | input | 1 | Synchronous active-high initialisation |
| osc_ready_i | input | 1 | Real-time oscillator has stabilised (asynchronous) |
| hv_valid_i | input | 1 | High-voltage input rail is valid (asynchronous) |
| core_valid_i | input | 1 | Core-logic rail is valid (asynchronous) |
| ext_rst_n_i | input | 1 | External reset request, active low; tie high if unused |
| rail_stable_i | input | N_STABLE | Per-rail stable flags for the regulated rails |
| por_int_n_o | output | 1 | Internal power-on reset, active low |
| sys_rst_n_o | output | 1 | Final combined system reset, active low |
| hold_o | output | 4 | Conditions still holding reset (see R10) |

## Verification
Every assertion of reset reaches the outputs combinationally. The bench therefore checks a falling input on the same half cycle, 0.2 ns after it drives the change. Every release is due a fixed number of edges after its input rises: two edges for the external and stable terms, and the delay plus two for each rail timer. Directed checks sample on the falling edge one cycle before and exactly at that edge. A behavioural model, updated on every rising edge, predicts all three outputs, and the bench compares them on each falling edge plus 1.5 ns, well clear of both clock edges.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;
  localparam int HOLD_W      = 4;
  localparam int HOLD_HV     = 0;
  localparam int HOLD_CORE   = 1;
  localparam int HOLD_EXT    = 2;
  localparam int HOLD_STABLE = 3;
  localparam int N_RAILS     = 2;
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int W     = 1,
  parameter bit GUARD = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  generate
    if (GUARD) begin : g_guard
      assign sync_o = stage1_q & stage2_q;
    end else begin : g_plain
      assign sync_o = stage2_q;
    end
  endgenerate

  a_r11_two_stage: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(stage2_q[0]) |-> $past(async_i[0], 2));
endmodule

// File: rtl/por_qual_timer.sv
module por_qual_timer #(
  parameter int LIMIT = 131
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic valid_s_i,
  input  logic osc_s_i,
  output logic done_o
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !valid_s_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (osc_s_i && !done_q) begin
      if (cnt_q == LAST) begin
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign done_o = done_q;

  a_r6_restart: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_s_i |=> (cnt_q == '0) && !done_q);
  a_r5_osc_gate: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_s_i && !osc_s_i && !done_q) |=> $stable(cnt_q) && !done_q);
  a_r2_done_holds: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_q && valid_s_i) |=> done_q);
endmodule

// File: rtl/por_seq.sv
module por_seq
  import por_seq_pkg::*;
#(
  parameter int HV_CYCLES   = 131,
  parameter int CORE_CYCLES = 33,
  parameter int N_STABLE    = 3
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                osc_ready_i,
  input  logic                hv_valid_i,
  input  logic                core_valid_i,
  input  logic                ext_rst_n_i,
  input  logic [N_STABLE-1:0] rail_stable_i,
  output logic                por_int_n_o,
  output logic                sys_rst_n_o,
  output logic [HOLD_W-1:0]   hold_o
);
  localparam int LVL_W   = 1 + N_RAILS;
  localparam int GUARD_W = 1 + N_STABLE;
  localparam int LIMITS [N_RAILS] = '{HV_CYCLES, CORE_CYCLES};

  logic [LVL_W-1:0]   lvl_s;
  logic [GUARD_W-1:0] grd_s;
  logic [N_RAILS-1:0] rail_raw;
  logic [N_RAILS-1:0] rail_done;
  logic [N_RAILS-1:0] rail_ok;
  logic               osc_s;
  logic               ext_ok;
  logic               stab_ok;

  assign rail_raw = {core_valid_i, hv_valid_i};

  por_sync #(.W(LVL_W), .GUARD(1'b0)) i_lvl_sync (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .async_i({rail_raw, osc_ready_i}),
    .sync_o (lvl_s)
  );

  por_sync #(.W(GUARD_W), .GUARD(1'b1)) i_grd_sync (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .async_i({rail_stable_i, ext_rst_n_i}),
    .sync_o (grd_s)
  );

  assign osc_s = lvl_s[0];

  generate
    for (genvar r = 0; r < N_RAILS; r++) begin : g_rail
      por_qual_timer #(.LIMIT(LIMITS[r])) i_timer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .valid_s_i(lvl_s[1+r]),
        .osc_s_i  (osc_s),
        .done_o   (rail_done[r])
      );
      assign rail_ok[r] = rail_done[r] & rail_raw[r];
    end
  endgenerate

  assign ext_ok  = ext_rst_n_i & grd_s[0];
  assign stab_ok = (&rail_stable_i) & (&grd_s[GUARD_W-1:1]);

  assign por_int_n_o = &rail_ok;
  assign sys_rst_n_o = por_int_n_o & ext_ok & stab_ok;

  always_comb begin
    hold_o              = '0;
    hold_o[HOLD_HV]     = ~rail_ok[0];
    hold_o[HOLD_CORE]   = ~rail_ok[1];
    hold_o[HOLD_EXT]    = ~ext_ok;
    hold_o[HOLD_STABLE] = ~stab_ok;
  end

  a_r4_release_needs_rails: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(por_int_n_o) |-> $past(hv_valid_i) && $past(core_valid_i));
  a_r8_ext_holds: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(ext_rst_n_i) |-> !sys_rst_n_o);
  a_r9_stable_holds: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(&rail_stable_i) |-> !sys_rst_n_o);
  a_r10_status_match: assert property (@(posedge clk_i) disable iff (rst_i)
    sys_rst_n_o |-> (hold_o == '0));
endmodule

// File: tb/test_por_seq.sv
module test_por_seq;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int HV   = 131;
  localparam int CORE = 33;
  localparam int NS   = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          osc, hv, core, ext;
  logic [NS-1:0] stab;
  logic          por_int_n, sys_rst_n;
  logic [3:0]    hold;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  por_seq #(.HV_CYCLES(HV), .CORE_CYCLES(CORE), .N_STABLE(NS)) i_por_seq (
    .clk_i(clk), .rst_i(rst), .osc_ready_i(osc), .hv_valid_i(hv),
    .core_valid_i(core), .ext_rst_n_i(ext), .rail_stable_i(stab),
    .por_int_n_o(por_int_n), .sys_rst_n_o(sys_rst_n), .hold_o(hold)
  );

  // behavioural reference model
  int      m_hv_n, m_core_n;
  bit      m_hv_done, m_core_done;
  bit      m_osc_sh [2];
  bit      m_hv_sh [2];
  bit      m_core_sh [2];
  bit      m_ext_sh [2];
  bit      m_stab_sh [2];

  always @(posedge clk) begin
    if (rst) begin
      m_hv_n = 0; m_core_n = 0; m_hv_done = 0; m_core_done = 0;
      m_osc_sh = '{0, 0}; m_hv_sh = '{0, 0}; m_core_sh = '{0, 0};
      m_ext_sh = '{0, 0}; m_stab_sh = '{0, 0};
    end else begin
      if (!m_hv_sh[1]) begin m_hv_n = 0; m_hv_done = 0; end
      else if (m_osc_sh[1] && !m_hv_done) begin
        m_hv_n++;
        if (m_hv_n == HV) m_hv_done = 1;
      end
      if (!m_core_sh[1]) begin m_core_n = 0; m_core_done = 0; end
      else if (m_osc_sh[1] && !m_core_done) begin
        m_core_n++;
        if (m_core_n == CORE) m_core_done = 1;
      end
      m_osc_sh[1] = m_osc_sh[0];   m_osc_sh[0] = osc;
      m_hv_sh[1] = m_hv_sh[0];     m_hv_sh[0] = hv;
      m_core_sh[1] = m_core_sh[0]; m_core_sh[0] = core;
      m_ext_sh[1] = m_ext_sh[0];   m_ext_sh[0] = ext;
      m_stab_sh[1] = m_stab_sh[0]; m_stab_sh[0] = &stab;
    end
  end

  task automatic fail_line(string req, int act, int exp);
    errors++;
    $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) fail_line(req, act, exp);
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #1.5;
    begin
      bit e_hv, e_core, e_ext, e_stab, e_int, e_sys;
      e_hv   = m_hv_done & hv;
      e_core = m_core_done & core;
      e_ext  = ext & m_ext_sh[0] & m_ext_sh[1];
      e_stab = (&stab) & m_stab_sh[0] & m_stab_sh[1];
      e_int  = e_hv & e_core;
      e_sys  = e_int & e_ext & e_stab;
      chk("R4 model por_int_n", por_int_n, e_int);
      chk("R10 model sys_rst_n", sys_rst_n, e_sys);
      chk("R10 model hold", hold, {~e_stab, ~e_ext, ~e_core, ~e_hv});
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #800000;
    fail_line("watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; osc = 0; hv = 0; core = 0; ext = 0; stab = '0;
    wait_n(3); #1;
    chk("R1 reset por_int_n", por_int_n, 0);
    chk("R1 reset sys_rst_n", sys_rst_n, 0);
    chk("R1 reset hold", hold, 4'hF);
    @(negedge clk);
    rst = 0; osc = 1; ext = 1; stab = '1;
    wait_n(2); #1;
    chk("R10 only rails hold", hold, 4'b0011);
    // core first, hv later: either order
    @(negedge clk); core = 1;
    wait_n(CORE + 1); #1;
    chk("R3 core not yet", hold[1], 1);
    wait_n(1); #1;
    chk("R3 core qualified", hold[1], 0);
    @(negedge clk); hv = 1;
    wait_n(HV + 1); #1;
    chk("R2 hv not yet", por_int_n, 0);
    wait_n(1); #1;
    chk("R2 R4 released", por_int_n, 1);
    chk("R4 sys released", sys_rst_n, 1);
    // R7: asynchronous re-assertion
    @(negedge clk); #1; core = 0; #0.2;
    chk("R7 core drop immediate", por_int_n, 0);
    chk("R7 sys drop immediate", sys_rst_n, 0);
    wait_n(4); core = 1;
    wait_n(CORE + 2); #1;
    chk("R6 core requalified", hold[1], 0);
    // R6: drop hv before done, restart from zero
    @(negedge clk); #1; hv = 0; #0.2;
    chk("R7 hv drop immediate", por_int_n, 0);
    wait_n(4); hv = 1;
    wait_n(60); hv = 0;
    wait_n(4); hv = 1;
    wait_n(HV + 1); #1;
    chk("R6 restart not early", por_int_n, 0);
    wait_n(1); #1;
    chk("R6 restart full count", por_int_n, 1);
    // R8 external reset
    @(negedge clk); #1; ext = 0; #0.2;
    chk("R8 ext immediate", sys_rst_n, 0);
    chk("R10 ext bit", hold, 4'b0100);
    wait_n(3); ext = 1;
    wait_n(1); #1;
    chk("R8 ext still held", sys_rst_n, 0);
    wait_n(1); #1;
    chk("R8 ext released", sys_rst_n, 1);
    // R9 stable flags
    @(negedge clk); #1; stab = 3'b101; #0.2;
    chk("R9 stable immediate", sys_rst_n, 0);
    chk("R10 stable bit", hold, 4'b1000);
    chk("R9 por_int unaffected", por_int_n, 1);
    wait_n(3); stab = '1;
    wait_n(1); #1;
    chk("R9 stable still held", sys_rst_n, 0);
    wait_n(1); #1;
    chk("R9 stable released", sys_rst_n, 1);
    // R5 oscillator gating after re-initialisation
    @(negedge clk); rst = 1; osc = 0;
    wait_n(2); rst = 0;
    wait_n(300); #1;
    chk("R5 no count without osc", hold[1:0], 2'b11);
    @(negedge clk); osc = 1;
    wait_n(CORE + 1); #1;
    chk("R5 core waits osc", hold[1], 1);
    wait_n(1); #1;
    chk("R5 core after osc", hold[1], 0);
    wait_n(HV - CORE - 1); #1;
    chk("R5 hv waits osc", por_int_n, 0);
    wait_n(1); #1;
    chk("R5 hv after osc", por_int_n, 1);
    wait_n(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule